// File: doc/BRIEF.md
# Byte Receive Queue and Transmit Strobe Register Block

This block is the register front end of a simple serial port. A host reaches it through a word-wide register bus with a single-cycle access. Bytes from a receiver come in over a byte-wide valid/ready handshake and wait in an eight-entry receive queue until the host reads them. A byte the host writes to the transmit register leaves at once as a one-cycle strobe carrying that byte. Bit-level serial framing and baud timing are handled elsewhere.

A status word shows the queue state and a sticky pending flag. The flag is raised by queued receive data or by any transmit write. A control word holds a receive-queue clear command and an interrupt enable. The single interrupt output is a level signal. It is the pending flag qualified by that enable. The error bits of the status word are always zero.

Top module: `sio_regs`

## Requirements
- R1: Byte address bits [3:2] select the register: 0 receive data, 1 transmit data, 2 status, 3 control. Address bits [1:0] are ignored. Read data is combinational and valid in the cycle the access is presented.
- R2: The receive queue holds up to 8 bytes. in_ready is high exactly when fewer than 8 are held. A byte is stored on a clock edge where in_valid and in_ready are both high.
- R3: A byte offered while 8 bytes are held is discarded. The queued contents and their order are unchanged.
- R4: A read of the receive register returns the oldest byte and removes it. If a byte is pushed in the same cycle as a read, the count stays the same and order is preserved.
- R5: A read of the receive register while the queue is empty returns the byte stored in the current head slot and leaves the count at zero.
- R6: Status bits: bit0 = queue not empty, bit1 = queue holds 8, bit2 = 1 (transmit side empty), bit3 = 0, bit4 = interrupt pending, bits 5..7 (overrun, framing, parity) = 0, bits 31..8 = 0.
- R7: A control write stores the full 32-bit value, and it reads back unchanged. If bit1 of that value is set, the queue count and pointers are cleared. A byte pushed in the same cycle becomes the only entry.
- R8: A write to the status register changes nothing: control, transmit readback, queue and pending flag.
- R9: A transmit write raises out_stb for exactly the next clock cycle, with out_byte equal to write data [7:0]. The transmit register reads back the full written word.
- R10: The pending flag (status bit4) is set by any transmit write and whenever the queue is non-empty. It stays set until reset.
- R11: irq is high exactly when the pending flag and control bit4 are both 1.
- R12: The synchronous active-high reset empties the queue and clears the queue storage, control, the transmit value and the pending flag. After reset: in_ready = 1, irq = 0, out_stb = 0, status reads 0x4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits [3:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| in_byte | input | 8 | Received byte |
| in_valid | input | 1 | Received byte is offered |
| in_ready | output | 1 | Queue can take a byte |
| out_byte | output | 8 | Transmit byte |
| out_stb | output | 1 | One-cycle transmit strobe |
| irq | output | 1 | Level interrupt |

## Verification
Two queue functions can fall in the same cycle: a host read that removes the head and an incoming byte, and a control write with the clear bit set together with an incoming byte. The bench provokes each one by raising in_valid during the bus access. It judges the simultaneous read and push by the byte returned and the order of the remaining reads, which shows the count did not change. It judges the clear-plus-push case by reading back only the new byte, followed by an empty status.

// File: rtl/sio_pkg.sv
package sio_pkg;

    // Register index taken from byte address bits [3:2]
    typedef enum logic [1:0] {
        REG_RXD  = 2'd0,
        REG_TXD  = 2'd1,
        REG_STAT = 2'd2,
        REG_CTRL = 2'd3
    } reg_idx_e;

    // Status word bit positions
    localparam int ST_NONEMPTY = 0;
    localparam int ST_FULL     = 1;
    localparam int ST_TXEMPTY  = 2;
    localparam int ST_TXFULL   = 3;
    localparam int ST_PEND     = 4;
    localparam int ST_OVR      = 5;
    localparam int ST_FRM      = 6;
    localparam int ST_PAR      = 7;

    // Control word bit positions
    localparam int CT_TXCLR = 0;
    localparam int CT_RXCLR = 1;
    localparam int CT_IE    = 4;

endpackage

// File: rtl/sio_rxq.sv
module sio_rxq #(
    parameter int DEPTH = 8,
    parameter int DW    = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push,
    input  logic [DW-1:0]               push_data,
    input  logic                        pop,
    input  logic                        clr,
    output logic                        ready,
    output logic [DW-1:0]               head,
    output logic [$clog2(DEPTH):0]      count,
    output logic                        held_next
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [CW-1:0]            cnt;
    } q_state_t;

    q_state_t s_q, s_d;

    logic          take;
    logic          drop_head;
    logic [PW-1:0] rp;
    logic [PW-1:0] wp_base;
    logic [CW-1:0] cnt_base;

    assign ready = (s_q.cnt != FULL_CNT);
    assign rp    = s_q.wp - s_q.cnt[PW-1:0];
    assign head  = s_q.mem[rp];
    assign count = s_q.cnt;

    always_comb begin
        s_d       = s_q;
        take      = push && ready;
        drop_head = pop && (s_q.cnt != '0);
        // a clear is applied first; a same-cycle byte lands in the emptied queue
        wp_base   = clr ? '0 : s_q.wp;
        cnt_base  = clr ? '0 : s_q.cnt;
        if (take) begin
            s_d.mem[wp_base] = push_data;
            s_d.wp           = wp_base + PW'(1);
        end else begin
            s_d.wp           = wp_base;
        end
        case ({take, drop_head && !clr})
            2'b10:   s_d.cnt = cnt_base + CW'(1);
            2'b01:   s_d.cnt = cnt_base - CW'(1);
            default: s_d.cnt = cnt_base;
        endcase
        held_next = (s_d.cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        s_q.cnt <= FULL_CNT);

    a_r2_push_counts: assert property (@(posedge clk) disable iff (rst)
        (push && ready && !pop && !clr) |=> (s_q.cnt == $past(s_q.cnt) + CW'(1)));

    a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
        (s_q.cnt == FULL_CNT && !pop && !clr) |=> (s_q.cnt == FULL_CNT));

    a_r5_empty_read: assert property (@(posedge clk) disable iff (rst)
        (s_q.cnt == '0 && pop && !push) |=> (s_q.cnt == '0));

endmodule

// File: rtl/sio_ctl.sv
module sio_ctl
    import sio_pkg::*;
#(
    parameter int BW  = 32,
    parameter int DW  = 8,
    parameter int CW  = 4,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    reg_idx,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic [DW-1:0] q_head,
    input  logic [CW-1:0] q_count,
    input  logic          q_held_next,
    output logic          q_pop,
    output logic          q_clr,
    output logic [DW-1:0] out_byte,
    output logic          out_stb,
    output logic          irq
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [BW-1:0] ctrl;
        logic [BW-1:0] txv;
        logic          pend;
        logic          stb;
        logic [DW-1:0] obyte;
    } c_state_t;

    c_state_t c_q, c_d;

    logic          wr_txd, wr_ctrl, wr_stat, rd_rxd;
    logic [BW-1:0] status_w;

    always_comb begin
        wr_txd  = bus_sel && bus_wr  && (reg_idx == REG_TXD);
        wr_ctrl = bus_sel && bus_wr  && (reg_idx == REG_CTRL);
        wr_stat = bus_sel && bus_wr  && (reg_idx == REG_STAT);
        rd_rxd  = bus_sel && !bus_wr && (reg_idx == REG_RXD);
        q_pop   = rd_rxd;
        q_clr   = wr_ctrl && bus_wdata[CT_RXCLR];
    end

    always_comb begin
        status_w              = '0;
        status_w[ST_NONEMPTY] = (q_count != '0);
        status_w[ST_FULL]     = (q_count == FULL_CNT);
        status_w[ST_TXEMPTY]  = 1'b1;
        status_w[ST_TXFULL]   = 1'b0;
        status_w[ST_PEND]     = c_q.pend;
        status_w[ST_OVR]      = 1'b0;
        status_w[ST_FRM]      = 1'b0;
        status_w[ST_PAR]      = 1'b0;
    end

    always_comb begin
        case (reg_idx)
            REG_RXD:  bus_rdata = BW'(q_head);
            REG_TXD:  bus_rdata = c_q.txv;
            REG_STAT: bus_rdata = status_w;
            default:  bus_rdata = c_q.ctrl;
        endcase
    end

    always_comb begin
        c_d      = c_q;
        c_d.stb  = wr_txd;
        if (wr_txd) begin
            c_d.txv   = bus_wdata;
            c_d.obyte = bus_wdata[DW-1:0];
        end
        if (wr_ctrl) begin
            c_d.ctrl = bus_wdata;
        end
        // sticky: only reset lowers it
        c_d.pend = c_q.pend || wr_txd || q_held_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign out_byte = c_q.obyte;
    assign out_stb  = c_q.stb;
    assign irq      = c_q.pend && c_q.ctrl[CT_IE];

    a_r9_strobe_data: assert property (@(posedge clk) disable iff (rst)
        wr_txd |=> (out_stb && out_byte == $past(bus_wdata[DW-1:0])));

    a_r9_strobe_single: assert property (@(posedge clk) disable iff (rst)
        !wr_txd |=> !out_stb);

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        c_q.pend |=> c_q.pend);

    a_r10_rx_raises: assert property (@(posedge clk) disable iff (rst)
        (q_count != '0) |-> c_q.pend);

    a_r8_status_ignored: assert property (@(posedge clk) disable iff (rst)
        wr_stat |=> ($stable(c_q.ctrl) && $stable(c_q.txv)));

    a_r11_enable_off: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !bus_wdata[CT_IE]) |=> !irq);

endmodule

// File: rtl/sio_regs.sv
module sio_regs #(
    parameter int DEPTH  = 8,
    parameter int DW     = 8,
    parameter int BW     = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BW-1:0]     bus_wdata,
    output logic [BW-1:0]     bus_rdata,
    input  logic [DW-1:0]     in_byte,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DW-1:0]     out_byte,
    output logic              out_stb,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [DW-1:0] q_head;
    logic [CW-1:0] q_count;
    logic          q_held_next;
    logic          q_pop;
    logic          q_clr;
    logic [1:0]    reg_idx;
    logic          unused_addr_bits;

    assign reg_idx          = bus_addr[3:2];
    assign unused_addr_bits = ^{bus_addr[1:0], bus_addr[ADDR_W-1:2]};

    sio_rxq #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .push      (in_valid),
        .push_data (in_byte),
        .pop       (q_pop),
        .clr       (q_clr),
        .ready     (in_ready),
        .head      (q_head),
        .count     (q_count),
        .held_next (q_held_next)
    );

    sio_ctl #(
        .BW    (BW),
        .DW    (DW),
        .CW    (CW),
        .DEPTH (DEPTH)
    ) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .reg_idx     (reg_idx),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .q_head      (q_head),
        .q_count     (q_count),
        .q_held_next (q_held_next),
        .q_pop       (q_pop),
        .q_clr       (q_clr),
        .out_byte    (out_byte),
        .out_stb     (out_stb),
        .irq         (irq)
    );

endmodule

// File: tb/sim_sio_regs.sv
`timescale 1ns/1ps
module sim_sio_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  in_byte = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  out_byte;
    logic        out_stb;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sio_regs u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_byte(in_byte), .in_valid(in_valid), .in_ready(in_ready),
        .out_byte(out_byte), .out_stb(out_stb), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk("R12 ready", 32'(in_ready), 1);
        chk("R12 irq", 32'(irq), 0);
        chk("R12 stb", 32'(out_stb), 0);
        bread(4'h8, d); chk("R12/R6 status", d, 32'h4);
        bread(4'hC, d); chk("R12 ctrl", d, 0);
        bread(4'h4, d); chk("R12 txv", d, 0);
    endtask

    task automatic t_order();
        logic [31:0] d;
        do_reset();
        push(8'h31); push(8'h32); push(8'h33);
        bread(4'h8, d); chk("R6/R10 status nonempty", d, 32'h15);
        chk("R11 irq disabled", 32'(irq), 0);
        bread(4'h0, d); chk("R4 first", d, 32'h31);
        bread(4'h3, d); chk("R1/R4 second low bits ignored", d, 32'h32);
        bread(4'h0, d); chk("R4 third", d, 32'h33);
        bread(4'h8, d); chk("R10 sticky after drain", d, 32'h14);
    endtask

    task automatic t_full();
        logic [31:0] d;
        do_reset();
        for (int i = 0; i < 8; i++) push(8'h80 + 8'(i));
        chk("R2 ready low at 8", 32'(in_ready), 0);
        bread(4'h8, d); chk("R6 status full", d, 32'h17);
        push(8'hEE);
        bread(4'h8, d); chk("R3 still full", d, 32'h17);
        for (int i = 0; i < 8; i++) begin
            bread(4'h0, d); chk("R3 order kept", d, 32'h80 + 32'(i));
        end
        bread(4'h8, d); chk("R3 empty after drain", d, 32'h14);
    endtask

    task automatic t_simul();
        logic [31:0] d;
        do_reset();
        push(8'hA1); push(8'hA2);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h0;
        in_valid = 1'b1; in_byte = 8'hA3;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0; in_valid = 1'b0;
        chk("R4 read during push", d, 32'hA1);
        bread(4'h0, d); chk("R4 next after same-cycle", d, 32'hA2);
        bread(4'h0, d); chk("R4 pushed byte", d, 32'hA3);
        bread(4'h8, d); chk("R4 count back to zero", d, 32'h14);
    endtask

    task automatic t_empty();
        logic [31:0] d;
        do_reset();
        push(8'h11); push(8'h22);
        bwrite(4'hC, 32'h2);
        bread(4'h8, d); chk("R7 clear empties", d, 32'h14);
        bread(4'h0, d); chk("R5 empty read slot", d, 32'h11);
        bread(4'h0, d); chk("R5 empty read again", d, 32'h11);
        bread(4'h8, d); chk("R5 count unchanged", d, 32'h14);
        bread(4'hC, d); chk("R7 ctrl stored", d, 32'h2);
    endtask

    task automatic t_clr_push();
        logic [31:0] d;
        do_reset();
        push(8'h01); push(8'h02); push(8'h03);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'hC; bus_wdata = 32'h2;
        in_valid = 1'b1; in_byte = 8'h77;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; in_valid = 1'b0;
        bread(4'h0, d); chk("R7 only new byte", d, 32'h77);
        bread(4'h8, d); chk("R7 empty after one read", d, 32'h14);
    endtask

    task automatic t_ctrl_status();
        logic [31:0] d;
        do_reset();
        bwrite(4'h4, 32'hCAFE0055);
        bwrite(4'hD, 32'hA5A50010);
        bread(4'hC, d); chk("R7 ctrl readback", d, 32'hA5A50010);
        chk("R11 irq on", 32'(irq), 1);
        push(8'h44);
        bwrite(4'h8, 32'hFFFFFFFF);
        bread(4'hC, d); chk("R8 ctrl untouched", d, 32'hA5A50010);
        bread(4'h4, d); chk("R8 txv untouched", d, 32'hCAFE0055);
        bread(4'h8, d); chk("R8 status untouched", d, 32'h15);
        bread(4'h0, d); chk("R8 queue untouched", d, 32'h44);
    endtask

    task automatic t_tx();
        logic [31:0] d;
        do_reset();
        bwrite(4'h4, 32'h123456C3);
        chk("R9 strobe high", 32'(out_stb), 1);
        chk("R9 byte", 32'(out_byte), 32'hC3);
        @(posedge clk); #1;
        chk("R9 strobe one cycle", 32'(out_stb), 0);
        bread(4'h4, d); chk("R9 tx readback", d, 32'h123456C3);
        bread(4'h8, d); chk("R10 tx sets pending", d, 32'h14);
        chk("R11 irq masked", 32'(irq), 0);
        bwrite(4'hC, 32'h10);
        chk("R11 irq enabled", 32'(irq), 1);
        bwrite(4'hC, 32'h0);
        chk("R11 irq disabled again", 32'(irq), 0);
        bread(4'h8, d); chk("R10 still pending", d, 32'h14);
        do_reset();
        bread(4'h8, d); chk("R12 reset clears pending", d, 32'h4);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_order();
        t_full();
        t_simul();
        t_empty();
        t_clr_push();
        t_ctrl_status();
        t_tx();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule